// File: doc/BRIEF.md
# Pulse-Train Transmitter From Memory

This block turns a list of timed levels held in a channel memory window into a waveform on a single output pin. Every 32-bit memory word carries two 16-bit entries. Each entry names an output level and a duration. The duration is counted in channel clock ticks, which arrive as a one-cycle enable on the system clock. A start strobe makes the block fetch words from the first address of its window and play the entries in order. Within a word the lower entry plays first and the upper entry second. An entry whose duration is zero ends the run.

The window is one or more whole blocks of `BLK_WORDS` words. Wraparound mode lets the transmitter loop from the last word back to word zero. A programmable entry-count threshold raises a pulse while the run is still going, so that software can refill words already played before the loop comes back to them. Outside a run the pin sits at a configurable idle level.

Top module: `pulse_tx`

## Requirements
- R1: An entry holds its level in bit 15 and its duration in bits 14:0. For each fetched word, entry bits 15:0 are played before entry bits 31:16.
- R2: A played entry holds the pin at its level for exactly its duration in ticks. The pin changes only after the last of those ticks.
- R3: An entry with a zero duration ends the run. `done` pulses high for one cycle, the pin returns to `idle_level` in that same cycle, and no memory read is made until the next start.
- R4: A start strobe while the block is idle makes the first read at address 0. A start strobe during a run, including one in the cycle the end marker is decoded, is ignored.
- R5: With `wrap_en` high, the word after the last word of the window is read from address 0.
- R6: With `wrap_en` low, finishing both entries of the last word of the window ends the run exactly as an end marker would.
- R7: `thr_evt` pulses for one cycle together with the pin change that starts entry number k·`thr_limit` (k ≥ 1, counted from the start of the run, end markers excluded). A limit of 0 disables it, and it never coincides with `done`.
- R8: While `rst` is high, `pin_out`, `done`, `thr_evt` and `mem_rd` are all 0. In each idle cycle after reset the pin follows `idle_level`.
- R9: `blk_sel` = b makes the window span words 0 to (b+1)·`BLK_WORDS`−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, acted on only when idle |
| tick | input | 1 | Channel-clock enable, one per duration unit |
| wrap_en | input | 1 | Loop from the window end back to word 0 |
| idle_level | input | 1 | Pin level outside a run |
| blk_sel | input | BNW | Number of window blocks minus one |
| thr_limit | input | CW | Entry count between threshold pulses, 0 = off |
| mem_rd | output | 1 | Memory read enable |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| pin_out | output | 1 | Registered output pin |
| done | output | 1 | One-cycle end-of-run pulse |
| thr_evt | output | 1 | One-cycle threshold pulse |

## Verification
One collision is built on purpose: a start strobe in the same cycle the end marker is decoded. The marker sits in the upper half of a word, so the bench knows that the decode cycle is exactly one cycle after the final tick of the previous entry. It raises `start` for that cycle only. The start is judged as dropped if the tick-sampled waveform matches the expected one, `done` fires, and then for 24 cycles there is no read and the pin stays at idle. A second pair, the threshold pulse and the wraparound fetch, is provoked by setting the limit to the window's entry count and refilling word 0 when the pulse arrives. The run must then go on with the new entries after the wrap.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int ENTRY_W = 16;
  localparam int DUR_W   = ENTRY_W - 1;

  typedef struct packed {
    logic             level;
    logic [DUR_W-1:0] dur;
  } ptx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_LOAD,
    S_ENTRY,
    S_HOLD
  } ptx_state_e;
endpackage

// File: rtl/ptx_win_addr.sv
module ptx_win_addr #(
  parameter int BLK_WORDS = 64,
  parameter int MAX_BLKS  = 8,
  parameter int AW        = 9,
  parameter int BNW       = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           adv,
  input  logic [BNW-1:0] blk_sel,
  output logic [AW-1:0]  addr,
  output logic           at_last
);
  logic [AW-1:0] last_addr;

  assign last_addr = AW'(blk_sel) * AW'(BLK_WORDS) + AW'(BLK_WORDS - 1);
  assign at_last   = (addr == last_addr);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (clr)  addr <= '0;
    else if (adv)  addr <= at_last ? '0 : addr + AW'(1);
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && !at_last) |=> (addr == $past(addr) + AW'(1))); // R4
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && at_last) |=> (addr == '0)); // R5
endmodule

// File: rtl/ptx_dur_cnt.sv
module ptx_dur_cnt
  import ptx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [DUR_W-1:0] cnt;

  assign expire = tick && (cnt == DUR_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - DUR_W'(1);
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0)); // R3
endmodule

// File: rtl/ptx_thr_cnt.sv
module ptx_thr_cnt #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          evt
);
  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = (limit != '0) && (cnt + CW'(1) == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (inc) begin
        evt <= hit;
        cnt <= hit ? '0 : cnt + CW'(1);
      end
    end
  end

  AST_THR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt); // R7
endmodule

// File: rtl/pulse_tx.sv
module pulse_tx
  import ptx_pkg::*;
#(
  parameter int BLK_WORDS = 64,
  parameter int MAX_BLKS  = 8,
  localparam int AW  = $clog2(BLK_WORDS * MAX_BLKS),
  localparam int BNW = (MAX_BLKS > 1) ? $clog2(MAX_BLKS) : 1,
  localparam int CW  = AW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           tick,
  input  logic           wrap_en,
  input  logic           idle_level,
  input  logic [BNW-1:0] blk_sel,
  input  logic [CW-1:0]  thr_limit,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  input  logic [31:0]    mem_rdata,
  output logic           pin_out,
  output logic           done,
  output logic           thr_evt
);
  ptx_state_e state;
  logic [31:0] word_q;
  logic        half;
  ptx_entry_t  cur;
  logic        at_last, expire, hold_end;
  logic        addr_clr, addr_adv, dur_load;

  assign cur      = half ? ptx_entry_t'(word_q[31:16]) : ptx_entry_t'(word_q[15:0]);
  assign hold_end = (state == S_HOLD) && expire;
  assign addr_clr = (state == S_IDLE) && start;
  assign addr_adv = hold_end && half && (!at_last || wrap_en);
  assign dur_load = (state == S_ENTRY) && (cur.dur != '0);
  assign mem_rd   = (state == S_FETCH);

  ptx_win_addr #(
    .BLK_WORDS(BLK_WORDS), .MAX_BLKS(MAX_BLKS), .AW(AW), .BNW(BNW)
  ) u_addr (
    .clk(clk), .rst(rst), .clr(addr_clr), .adv(addr_adv),
    .blk_sel(blk_sel), .addr(mem_addr), .at_last(at_last)
  );

  ptx_dur_cnt u_dur (
    .clk(clk), .rst(rst), .load(dur_load), .load_val(cur.dur),
    .tick(tick), .expire(expire)
  );

  ptx_thr_cnt #(.CW(CW)) u_thr (
    .clk(clk), .rst(rst), .clr(addr_clr), .inc(dur_load),
    .limit(thr_limit), .evt(thr_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      word_q  <= '0;
      half    <= 1'b0;
      pin_out <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          pin_out <= idle_level;
          if (start) state <= S_FETCH;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          word_q <= mem_rdata;
          half   <= 1'b0;
          state  <= S_ENTRY;
        end
        S_ENTRY: begin
          if (cur.dur == '0) begin
            pin_out <= idle_level;
            done    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            pin_out <= cur.level;
            state   <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (expire) begin
            if (!half) begin
              half  <= 1'b1;
              state <= S_ENTRY;
            end else if (!at_last || wrap_en) begin
              state <= S_FETCH;
            end else begin
              pin_out <= idle_level;
              done    <= 1'b1;
              state   <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && !tick) |=> $stable(pin_out)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (pin_out == $past(idle_level))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_WIN_END_STOP: assert property (@(posedge clk) disable iff (rst)
    (hold_end && half && at_last && !wrap_en) |=> (done && !mem_rd)); // R6
  AST_THR_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    done |-> !thr_evt); // R7
endmodule

// File: tb/tb_pulse_tx.sv
module tb_pulse_tx;
  localparam int BLK = 4;
  localparam int NBL = 2;
  localparam int AW  = $clog2(BLK * NBL);
  localparam int CW  = AW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wrap_en = 1'b0;
  logic idle_level = 1'b0;
  logic [0:0] blk_sel = '0;
  logic [CW-1:0] thr_limit = '0;
  logic tick;
  logic mem_rd, pin_out, done, thr_evt;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [0:7];
  logic [2:0] tcnt = '0;

  int nchk = 0;
  int nfail = 0;
  bit exp_s [0:255];
  bit got_s [0:255];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= tcnt + 3'd1;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end
  assign tick = (tcnt == 3'd7);

  pulse_tx #(.BLK_WORDS(BLK), .MAX_BLKS(NBL)) dut (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .wrap_en(wrap_en),
    .idle_level(idle_level), .blk_sel(blk_sel), .thr_limit(thr_limit),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pin_out(pin_out), .done(done), .thr_evt(thr_evt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ent(input int i, input bit idl, input int seed);
    logic lvl;
    lvl = ~idl ^ i[0];
    return {lvl, 15'(((i * 3 + seed) % 4) + 1)};
  endfunction

  task automatic run_case(input int n, input bit marker, input bit bsel,
                          input bit wrap, input bit idl, input int lim,
                          input bit poke, input bit refill, input int seed);
    int total, exp_n, got_n, first_addr, post, trans, thr_n, exp_thr, pokecnt;
    bit done_seen, fin, rd_after, pin_bad, thr_bad, prev, seq_ok;
    logic [15:0] lo, hi;
    string lreq;
    total = refill ? n + 2 : n;
    blk_sel = bsel;
    wrap_en = wrap;
    idle_level = idl;
    thr_limit = CW'(lim);
    for (int w = 0; w < 8; w++) begin
      lo = (2*w < n) ? ent(2*w, idl, seed) : ((2*w == n && marker) ? 16'h0000 : 16'h8003);
      hi = (2*w+1 < n) ? ent(2*w+1, idl, seed) : ((2*w+1 == n && marker) ? 16'h0000 : 16'h8003);
      mem[w] = {hi, lo};
    end
    exp_n = 0;
    for (int i = 0; i < total; i++) begin
      for (int d = 0; d < ((i * 3 + seed) % 4) + 1; d++) begin
        exp_s[exp_n] = ~idl ^ i[0];
        exp_n++;
      end
    end
    exp_thr = (lim == 0) ? 0 : total / lim;
    repeat (3) @(negedge clk);
    while (!tick) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_n = 0; first_addr = -1; post = 0; trans = 0; thr_n = 0; pokecnt = 0;
    done_seen = 0; fin = 0; rd_after = 0; pin_bad = 0; thr_bad = 0; prev = idl;
    for (int k = 0; k < 3000 && !fin; k++) begin
      start = 1'b0;
      if (mem_rd && !done_seen && first_addr < 0) first_addr = int'(mem_addr);
      if (done_seen) begin
        post++;
        if (mem_rd) rd_after = 1;
        if (pin_out !== idl) pin_bad = 1;
        if (post == 24) fin = 1;
      end else if (done) begin
        done_seen = 1;
        chk(pin_out === idl, "R3", "pin at done", int'(pin_out), int'(idl));
      end else begin
        if (pin_out !== prev) begin
          trans++;
          prev = pin_out;
        end
        if (thr_evt) begin
          thr_n++;
          if (lim == 0 || (trans % lim) != 0) thr_bad = 1;
          if (refill) begin
            mem[0] = {ent(9, idl, seed), ent(8, idl, seed)};
            mem[1] = 32'h0000_0000;
          end
        end
        if (pokecnt > 0) begin
          pokecnt--;
          if (pokecnt == 0) start = 1'b1;
        end
        if (tick && got_n < 256) begin
          got_s[got_n] = pin_out;
          got_n++;
          if (poke && got_n == exp_n) pokecnt = 1;
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    lreq = bsel ? "R9" : (marker ? "R2" : "R6");
    chk(done_seen, marker ? "R3" : "R6", "done seen", int'(done_seen), 1);
    chk(got_n == exp_n, lreq, "tick samples", got_n, exp_n);
    seq_ok = (got_n == exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got_s[i] != exp_s[i]) seq_ok = 0;
    chk(seq_ok, "R1", "level sequence match", int'(seq_ok), 1);
    if (total > 0 || !marker)
      chk(first_addr == 0, "R4", "first read addr", first_addr, 0);
    chk(!rd_after && !pin_bad, poke ? "R4" : "R3", "quiet after done",
        int'(rd_after) + 2 * int'(pin_bad), 0);
    chk(thr_n == exp_thr && !thr_bad, refill ? "R5" : "R7", "threshold pulses",
        thr_n, exp_thr);
  endtask

  initial begin
    for (int w = 0; w < 8; w++) mem[w] = 32'h8003_8003;
    repeat (4) @(negedge clk);
    chk(pin_out == 1'b0 && done == 1'b0 && thr_evt == 1'b0 && mem_rd == 1'b0,
        "R8", "reset outputs", int'({pin_out, done, thr_evt, mem_rd}), 0);
    rst = 1'b0;
    idle_level = 1'b1;
    repeat (2) @(negedge clk);
    chk(pin_out == 1'b1, "R8", "idle follows level", int'(pin_out), 1);
    for (int idl = 0; idl < 2; idl++)
      for (int n = 0; n < 8; n++)
        run_case(n, 1'b1, 1'b0, 1'b0, idl[0], (n % 3), 1'b0, 1'b0, n + idl);
    for (int b = 0; b < 2; b++)
      for (int idl = 0; idl < 2; idl++)
        run_case(8 * (b + 1), 1'b0, b[0], 1'b0, idl[0], 3, 1'b0, 1'b0, b + 2 * idl);
    run_case(8, 1'b0, 1'b0, 1'b1, 1'b0, 8, 1'b0, 1'b1, 1);
    run_case(8, 1'b0, 1'b0, 1'b1, 1'b1, 8, 1'b0, 1'b1, 2);
    run_case(5, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b0, 3);
    run_case(3, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b1, 1'b0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule